// File: doc/BRIEF.md
# Majority-Logic Row Sequencer

This block runs one row-wide vector operation over a small file of row registers. Each of the sixteen rows is a ROW_W-bit register standing in for one memory row, and every operation is built from three row-level primitives only: copy, bitwise three-input majority and bitwise inversion. The controller fetches and executes one command per cycle from a host-loaded command memory, so a new operation is added by loading a new sequence, not by changing the logic.

A host first writes data rows and one or more command sequences while the block is idle. It then presents a sequence start address, two operand row indices and a result row index, and pulses start. The controller copies the two operands into reserved compute rows, steps through the sequence without further host involvement, copies the reserved result row to the requested row when it reaches the end command, and pulses done. Rows 0 and 1 are hardwired to all-zeros and all-ones, so majority with one of them as third input gives AND or OR. Scratch rows keep their contents between runs, which lets a multi-bit operation on vertically stored operands (one bit position per row, one element per lane) be carried out as one run per bit position with the carry held in a scratch row.

Top module: `maj_row_seq`

## Requirements
- R1: Row 0 always reads all zeros and row 1 always reads all ones; host writes and sequence writes to either have no effect.
- R2: A command is 18 bits: kind in [17:16], destination row in [15:12], first source in [11:8], second source in [7:4], third source in [3:0]; kind 0 is copy, 1 is majority, 2 is invert, 3 is end.
- R3: A majority command writes (A&B)|(B&C)|(A&C) lane by lane into the destination in one cycle; with row 0 or row 1 as the third source the result is A AND B or A OR B.
- R4: An invert command writes ~A into the destination and a copy command writes A into the destination, each in one cycle.
- R5: In the cycle after an accepted start, row opnd_a is copied into row 10 and row opnd_b into row 11; in each following cycle one command is executed, starting at seq_base and advancing by one address.
- R6: The end command copies row 12 into row res_row; done is high for exactly one cycle, in the cycle after the end command executes, with busy low; a sequence of n commands including the end gives done n+1 cycles after the start edge.
- R7: While busy, start, command-memory writes and host row writes are ignored.
- R8: Compute and scratch rows keep their values between runs, so a carry left in row 13 by one run is used by the next.
- R9: If a command other than end executes at the last command address (63), err rises in the next cycle with busy low, done stays low and the result row is not written; err stays high until the next accepted start clears it.
- R10: A full-adder sequence of majority and invert commands, run once per bit position with the carry in row 13, produces the sum of two vertically stored operands in every lane.
- R11: A host write while idle is visible on row_rdata from the next cycle; row_rdata shows the addressed row combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_we | input | 1 | Command memory write strobe (idle only) |
| uop_addr | input | UOP_AW | Command memory write address |
| uop_wdata | input | 18 | Command word |
| row_we | input | 1 | Host row write strobe (idle only) |
| row_waddr | input | 4 | Host row write index |
| row_wdata | input | ROW_W | Host row write data |
| row_raddr | input | 4 | Host row read index |
| row_rdata | output | ROW_W | Contents of the addressed row |
| start | input | 1 | Begin a run (ignored while busy) |
| seq_base | input | UOP_AW | First command address of the run |
| opnd_a | input | 4 | Row copied into compute row 10 |
| opnd_b | input | 4 | Row copied into compute row 11 |
| res_row | input | 4 | Row receiving compute row 12 at the end |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after a run ends normally |
| err | output | 1 | Sequence ran off the end of command memory |

## Verification
The assertions watch, on every cycle, that done is a single-cycle pulse that only appears with the controller idle, that the command address advances by exactly one per executed command, that operand and result indices stay frozen when start arrives mid-run, that the error flag never rises together with done and holds until a new start, and that the two row write ports never target the same row. Whether the rows actually hold the right lane values can only be shown by the bench: it compares bit-serial additions over many random lane patterns against a reference adder, checks AND, OR and invert results, measures run latency, and confirms that the constant rows, the ignored writes during a run and the run-off error leave the observable rows as the requirements say.

// File: rtl/majseq_pkg.sv
package majseq_pkg;

   localparam int ROW_AW = 4;
   localparam int N_ROWS = 1 << ROW_AW;
   localparam int UOP_W  = 2 + 4 * ROW_AW;

   typedef enum logic [1:0] {
      OP_COPY = 2'd0,
      OP_MAJ  = 2'd1,
      OP_NOT  = 2'd2,
      OP_END  = 2'd3
   } uop_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MAP  = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_e;

   typedef struct packed {
      uop_kind_e         kind;
      logic [ROW_AW-1:0] dst;
      logic [ROW_AW-1:0] sa;
      logic [ROW_AW-1:0] sb;
      logic [ROW_AW-1:0] sc;
   } uop_t;

endpackage

// File: rtl/majseq_uop_store.sv
module majseq_uop_store
   import majseq_pkg::*;
#(
   parameter int UOP_AW = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [UOP_AW-1:0] waddr,
   input  logic [UOP_W-1:0]  wdata,
   input  logic [UOP_AW-1:0] raddr,
   output uop_t              rdata
);
   localparam int DEPTH = 1 << UOP_AW;

   logic [UOP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = uop_t'(mem[raddr]);

endmodule

// File: rtl/majseq_row_file.sv
module majseq_row_file
   import majseq_pkg::*;
#(
   parameter int ROW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we0,
   input  logic [ROW_AW-1:0] wa0,
   input  logic [ROW_W-1:0]  wd0,
   input  logic              we1,
   input  logic [ROW_AW-1:0] wa1,
   input  logic [ROW_W-1:0]  wd1,
   input  logic [ROW_AW-1:0] ra,
   input  logic [ROW_AW-1:0] rb,
   input  logic [ROW_AW-1:0] rc,
   input  logic [ROW_AW-1:0] rh,
   output logic [ROW_W-1:0]  da,
   output logic [ROW_W-1:0]  db,
   output logic [ROW_W-1:0]  dc,
   output logic [ROW_W-1:0]  dh
);
   logic [ROW_W-1:0] rows [N_ROWS];

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      if (r < 2) begin : g_const
         assign rows[r] = (r == 1) ? {ROW_W{1'b1}} : {ROW_W{1'b0}};
      end else begin : g_reg
         logic [ROW_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                 q <= '0;
            else if (we0 && (wa0 == ROW_AW'(r)))        q <= wd0;
            else if (we1 && (wa1 == ROW_AW'(r)))        q <= wd1;
         end
         assign rows[r] = q;
      end
   end

   assign da = rows[ra];
   assign db = rows[rb];
   assign dc = rows[rc];
   assign dh = rows[rh];

   // R5
   port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we0 && we1) |-> (wa0 != wa1));

endmodule

// File: rtl/majseq_alu.sv
module majseq_alu
   import majseq_pkg::*;
#(
   parameter int ROW_W = 16
) (
   input  uop_kind_e        kind,
   input  logic [ROW_W-1:0] a,
   input  logic [ROW_W-1:0] b,
   input  logic [ROW_W-1:0] c,
   output logic [ROW_W-1:0] y
);
   logic [ROW_W-1:0] maj_v;

   for (genvar i = 0; i < ROW_W; i++) begin : g_lane
      assign maj_v[i] = (a[i] & b[i]) | (b[i] & c[i]) | (a[i] & c[i]);
   end

   always_comb begin
      unique case (kind)
         OP_MAJ:  y = maj_v;
         OP_NOT:  y = ~a;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/majseq_ctrl.sv
module majseq_ctrl
   import majseq_pkg::*;
#(
   parameter int UOP_AW = 6,
   parameter int SLOT_A = 10,
   parameter int SLOT_B = 11,
   parameter int SLOT_Y = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [UOP_AW-1:0] seq_base,
   input  logic [ROW_AW-1:0] opa,
   input  logic [ROW_AW-1:0] opb,
   input  logic [ROW_AW-1:0] res,
   input  uop_t              uop,
   input  logic              host_we,
   input  logic [ROW_AW-1:0] host_wa,
   output logic [UOP_AW-1:0] pc,
   output logic              busy,
   output logic              done,
   output logic              err,
   output uop_kind_e         alu_kind,
   output logic [ROW_AW-1:0] ra,
   output logic [ROW_AW-1:0] rb,
   output logic [ROW_AW-1:0] rc,
   output logic              we0,
   output logic [ROW_AW-1:0] wa0,
   output logic              we1,
   output logic [ROW_AW-1:0] wa1,
   output logic              sel_host
);
   localparam logic [ROW_AW-1:0] RA_SLOT = ROW_AW'(SLOT_A);
   localparam logic [ROW_AW-1:0] RB_SLOT = ROW_AW'(SLOT_B);
   localparam logic [ROW_AW-1:0] RY_SLOT = ROW_AW'(SLOT_Y);
   localparam logic [UOP_AW-1:0] PC_LAST = {UOP_AW{1'b1}};

   seq_state_e        state_q;
   logic [UOP_AW-1:0] pc_q;
   logic [ROW_AW-1:0] opa_q, opb_q, res_q;
   logic              done_q, err_q;
   logic              accept, at_end;

   assign accept = (state_q == ST_IDLE) && start;
   assign at_end = (state_q == ST_RUN) && (uop.kind == OP_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= at_end;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_MAP;
               pc_q    <= seq_base;
               opa_q   <= opa;
               opb_q   <= opb;
               res_q   <= res;
               err_q   <= 1'b0;
            end
            ST_MAP: state_q <= ST_RUN;
            ST_RUN: begin
               if (uop.kind == OP_END) begin
                  state_q <= ST_IDLE;
               end else if (pc_q == PC_LAST) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b1;
               end else begin
                  pc_q <= pc_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      alu_kind = OP_COPY;
      ra       = '0;
      rb       = '0;
      rc       = '0;
      we0      = 1'b0;
      wa0      = '0;
      we1      = 1'b0;
      wa1      = '0;
      sel_host = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            sel_host = 1'b1;
            we0      = host_we;
            wa0      = host_wa;
         end
         ST_MAP: begin
            ra  = opa_q;
            rb  = opb_q;
            we0 = 1'b1;
            wa0 = RA_SLOT;
            we1 = 1'b1;
            wa1 = RB_SLOT;
         end
         ST_RUN: begin
            we0 = 1'b1;
            if (uop.kind == OP_END) begin
               ra  = RY_SLOT;
               wa0 = res_q;
            end else begin
               alu_kind = uop.kind;
               ra       = uop.sa;
               rb       = uop.sb;
               rc       = uop.sc;
               wa0      = uop.dst;
            end
         end
         default: ;
      endcase
   end

   assign pc   = pc_q;
   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign err  = err_q;

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE));

   // R5
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RUN) && ($past(state_q) == ST_RUN)) |-> (pc_q == $past(pc_q) + 1'b1));

   // R7
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && start) |=> ($stable(opa_q) && $stable(opb_q) && $stable(res_q)));

   // R9
   err_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (!done_q && (state_q == ST_IDLE)));

   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !accept) |=> err_q);

endmodule

// File: rtl/maj_row_seq.sv
module maj_row_seq
   import majseq_pkg::*;
#(
   parameter int ROW_W  = 16,
   parameter int UOP_AW = 6,
   parameter int SLOT_A = 10,
   parameter int SLOT_B = 11,
   parameter int SLOT_Y = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uop_we,
   input  logic [UOP_AW-1:0] uop_addr,
   input  logic [UOP_W-1:0]  uop_wdata,
   input  logic              row_we,
   input  logic [ROW_AW-1:0] row_waddr,
   input  logic [ROW_W-1:0]  row_wdata,
   input  logic [ROW_AW-1:0] row_raddr,
   output logic [ROW_W-1:0]  row_rdata,
   input  logic              start,
   input  logic [UOP_AW-1:0] seq_base,
   input  logic [ROW_AW-1:0] opnd_a,
   input  logic [ROW_AW-1:0] opnd_b,
   input  logic [ROW_AW-1:0] res_row,
   output logic              busy,
   output logic              done,
   output logic              err
);
   if (ROW_W < 1) begin : g_bad_width
      $error("ROW_W must be at least 1");
   end
   if (UOP_AW < 1 || UOP_AW > 10) begin : g_bad_depth
      $error("UOP_AW must lie in 1..10");
   end
   if (SLOT_A < 2 || SLOT_B < 2 || SLOT_Y < 2 ||
       SLOT_A >= N_ROWS || SLOT_B >= N_ROWS || SLOT_Y >= N_ROWS) begin : g_bad_slot
      $error("compute slots must be writable rows");
   end
   if (SLOT_A == SLOT_B) begin : g_slot_clash
      $error("operand slots must differ");
   end

   uop_t              cur_uop;
   logic [UOP_AW-1:0] pc;
   uop_kind_e         alu_kind;
   logic [ROW_AW-1:0] ra, rb, rc, wa0, wa1;
   logic              we0, we1, sel_host;
   logic [ROW_W-1:0]  da, db, dc, alu_y, wd0;

   majseq_uop_store #(.UOP_AW(UOP_AW)) u_store (
      .clk   (clk),
      .we    (uop_we && !busy),
      .waddr (uop_addr),
      .wdata (uop_wdata),
      .raddr (pc),
      .rdata (cur_uop)
   );

   majseq_ctrl #(
      .UOP_AW(UOP_AW), .SLOT_A(SLOT_A), .SLOT_B(SLOT_B), .SLOT_Y(SLOT_Y)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .seq_base (seq_base),
      .opa      (opnd_a),
      .opb      (opnd_b),
      .res      (res_row),
      .uop      (cur_uop),
      .host_we  (row_we),
      .host_wa  (row_waddr),
      .pc       (pc),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .alu_kind (alu_kind),
      .ra       (ra),
      .rb       (rb),
      .rc       (rc),
      .we0      (we0),
      .wa0      (wa0),
      .we1      (we1),
      .wa1      (wa1),
      .sel_host (sel_host)
   );

   majseq_alu #(.ROW_W(ROW_W)) u_alu (
      .kind (alu_kind),
      .a    (da),
      .b    (db),
      .c    (dc),
      .y    (alu_y)
   );

   assign wd0 = sel_host ? row_wdata : alu_y;

   majseq_row_file #(.ROW_W(ROW_W)) u_rows (
      .clk   (clk),
      .rst_n (rst_n),
      .we0   (we0),
      .wa0   (wa0),
      .wd0   (wd0),
      .we1   (we1),
      .wa1   (wa1),
      .wd1   (db),
      .ra    (ra),
      .rb    (rb),
      .rc    (rc),
      .rh    (row_raddr),
      .da    (da),
      .db    (db),
      .dc    (dc),
      .dh    (row_rdata)
   );

endmodule

// File: tb/maj_row_seq_bench.sv
module maj_row_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W  = 16;
   localparam int UOP_AW = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              uop_we = 1'b0;
   logic [UOP_AW-1:0] uop_addr = '0;
   logic [17:0]       uop_wdata = '0;
   logic              row_we = 1'b0;
   logic [3:0]        row_waddr = '0;
   logic [ROW_W-1:0]  row_wdata = '0;
   logic [3:0]        row_raddr = '0;
   logic [ROW_W-1:0]  row_rdata;
   logic              start = 1'b0;
   logic [UOP_AW-1:0] seq_base = '0;
   logic [3:0]        opnd_a = '0, opnd_b = '0, res_row = '0;
   logic              busy, done, err;

   int checks = 0;
   int errors = 0;
   int cyc_total = 0;

   maj_row_seq #(.ROW_W(ROW_W), .UOP_AW(UOP_AW)) u_maj_row_seq (
      .clk(clk), .rst_n(rst_n), .uop_we(uop_we), .uop_addr(uop_addr),
      .uop_wdata(uop_wdata), .row_we(row_we), .row_waddr(row_waddr),
      .row_wdata(row_wdata), .row_raddr(row_raddr), .row_rdata(row_rdata),
      .start(start), .seq_base(seq_base), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .res_row(res_row), .busy(busy), .done(done), .err(err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc_total <= cyc_total + 1;
      if (cyc_total > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // command kinds (R2): 0 copy, 1 majority, 2 invert, 3 end
   function automatic logic [17:0] enc(input logic [1:0] k, input logic [3:0] d,
                                       input logic [3:0] a, input logic [3:0] b,
                                       input logic [3:0] c);
      return {k, d, a, b, c};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_uop(input int addr, input logic [17:0] w);
      @(negedge clk);
      uop_we = 1'b1; uop_addr = UOP_AW'(addr); uop_wdata = w;
      @(negedge clk);
      uop_we = 1'b0;
   endtask

   task automatic wr_row(input int r, input logic [ROW_W-1:0] v);
      @(negedge clk);
      row_we = 1'b1; row_waddr = 4'(r); row_wdata = v;
      @(negedge clk);
      row_we = 1'b0;
   endtask

   task automatic rd_row(input int r, output logic [ROW_W-1:0] v);
      @(negedge clk);
      row_raddr = 4'(r);
      #1 v = row_rdata;
   endtask

   task automatic run_seq(input int base, input int a, input int b, input int res,
                          input bit inject, output int cyc, output bit saw_done,
                          output bit done_next, output bit err_end);
      @(negedge clk);
      start = 1'b1; seq_base = UOP_AW'(base);
      opnd_a = 4'(a); opnd_b = 4'(b); res_row = 4'(res);
      @(posedge clk);
      #1 start = 1'b0;
      cyc = 0; saw_done = 1'b0; done_next = 1'b0;
      while (cyc < 200) begin
         @(posedge clk);
         #1 cyc++;
         if (inject && cyc == 2) begin
            start = 1'b1; seq_base = 6'd12; opnd_a = 4'd9; res_row = 4'd2;
            row_we = 1'b1; row_waddr = 4'd5; row_wdata = 16'hdead;
            uop_we = 1'b1; uop_addr = 6'd12; uop_wdata = enc(2'd2, 4'd12, 4'd10, 4'd0, 4'd0);
         end
         if (inject && cyc == 3) begin
            start = 1'b0; row_we = 1'b0; uop_we = 1'b0;
         end
         if (done) begin
            saw_done = 1'b1;
            break;
         end
         if (!busy) break;
      end
      err_end = err;
      if (saw_done) begin
         @(posedge clk);
         #1 done_next = done;
      end
   endtask

   task automatic add_case(input logic [ROW_W-1:0] a0, input logic [ROW_W-1:0] a1,
                           input logic [ROW_W-1:0] b0, input logic [ROW_W-1:0] b1,
                           input bit inject);
      int cyc; bit sd, dn, er;
      logic [ROW_W-1:0] s0, s1, s2, v5;
      wr_row(2, a0); wr_row(3, a1); wr_row(4, b0); wr_row(5, b1);
      run_seq(8, 2, 2, 9, 1'b0, cyc, sd, dn, er);
      run_seq(0, 2, 4, 6, 1'b0, cyc, sd, dn, er);
      chk(cyc == 8, "R6", "add latency", 64'(cyc), 64'd8);
      chk(sd && !dn, "R6", "done single pulse", {62'd0, sd, dn}, 64'd2);
      run_seq(0, 3, 5, 7, inject, cyc, sd, dn, er);
      if (inject) chk(sd && cyc == 8, "R7", "run unaffected by mid-run start", 64'(cyc), 64'd8);
      run_seq(10, 2, 2, 8, 1'b0, cyc, sd, dn, er);
      rd_row(6, s0); rd_row(7, s1); rd_row(8, s2);
      for (int j = 0; j < ROW_W; j++) begin
         logic [2:0] sum;
         sum = {1'b0, a1[j], a0[j]} + {1'b0, b1[j], b0[j]};
         chk({s2[j], s1[j], s0[j]} == sum, "R10", $sformatf("lane %0d sum", j),
             64'({s2[j], s1[j], s0[j]}), 64'(sum));
      end
      if (inject) begin
         rd_row(5, v5);
         chk(v5 == b1, "R7", "host row write ignored while busy", 64'(v5), 64'(b1));
      end
   endtask

   initial begin
      int cyc; bit sd, dn, er;
      logic [ROW_W-1:0] v, x, y;
      void'($urandom(32'd20240611));

      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset state
      #1;
      chk(!busy && !done && !err, "R6", "reset outputs", {61'd0, busy, done, err}, 64'd0);
      rd_row(5, v);  chk(v == '0, "R11", "row 5 after reset", 64'(v), 64'd0);
      rd_row(1, v);  chk(v == '1, "R1", "row 1 reads ones", 64'(v), 64'hffff);

      // full adder: carry into 14, sum into 12 (R2 field layout)
      load_uop(0, enc(2'd2, 4'd14, 4'd13, 4'd0, 4'd0));
      load_uop(1, enc(2'd1, 4'd15, 4'd10, 4'd11, 4'd14));
      load_uop(2, enc(2'd1, 4'd14, 4'd10, 4'd11, 4'd13));
      load_uop(3, enc(2'd2, 4'd12, 4'd14, 4'd0, 4'd0));
      load_uop(4, enc(2'd1, 4'd12, 4'd12, 4'd13, 4'd15));
      load_uop(5, enc(2'd0, 4'd13, 4'd14, 4'd0, 4'd0));
      load_uop(6, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(8, enc(2'd0, 4'd13, 4'd0, 4'd0, 4'd0));
      load_uop(9, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(10, enc(2'd0, 4'd12, 4'd13, 4'd0, 4'd0));
      load_uop(11, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(12, enc(2'd1, 4'd12, 4'd10, 4'd11, 4'd0));
      load_uop(13, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(14, enc(2'd1, 4'd12, 4'd10, 4'd11, 4'd1));
      load_uop(15, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(16, enc(2'd2, 4'd12, 4'd10, 4'd0, 4'd0));
      load_uop(17, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      load_uop(18, enc(2'd0, 4'd12, 4'd10, 4'd0, 4'd0));
      load_uop(19, enc(2'd3, 4'd0, 4'd0, 4'd0, 4'd0));
      for (int k = 60; k < 64; k++) load_uop(k, enc(2'd0, 4'd14, 4'd2, 4'd0, 4'd0));

      // R10 / R8: directed and random bit-serial additions
      add_case('1, '1, '1, '1, 1'b0);
      add_case('0, '0, '0, '0, 1'b0);
      add_case(16'h00ff, 16'h0f0f, 16'h3333, 16'h5555, 1'b1);
      for (int it = 0; it < 8; it++)
         add_case(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'b0);

      // R3 / R4 and R7 (command at 12 must still be AND)
      for (int it = 0; it < 6; it++) begin
         x = 16'($urandom); y = 16'($urandom);
         wr_row(2, x); wr_row(3, y);
         run_seq(12, 2, 3, 6, 1'b0, cyc, sd, dn, er);
         chk(cyc == 3, "R6", "two-command latency", 64'(cyc), 64'd3);
         rd_row(6, v); chk(v == (x & y), "R3", "majority with row 0 is AND", 64'(v), 64'(x & y));
         run_seq(14, 2, 3, 7, 1'b0, cyc, sd, dn, er);
         rd_row(7, v); chk(v == (x | y), "R3", "majority with row 1 is OR", 64'(v), 64'(x | y));
         run_seq(16, 2, 3, 8, 1'b0, cyc, sd, dn, er);
         rd_row(8, v); chk(v == ~x, "R4", "invert", 64'(v), 64'(~x));
         run_seq(18, 3, 2, 9, 1'b0, cyc, sd, dn, er);
         rd_row(9, v); chk(v == y, "R4", "copy", 64'(v), 64'(y));
      end

      // R1: constant rows
      wr_row(2, 16'hbeef); wr_row(3, 16'h0000);
      wr_row(0, 16'h1234);
      rd_row(0, v); chk(v == '0, "R1", "host write to row 0", 64'(v), 64'd0);
      run_seq(18, 2, 2, 0, 1'b0, cyc, sd, dn, er);
      rd_row(0, v); chk(v == '0, "R1", "sequence write to row 0", 64'(v), 64'd0);
      run_seq(18, 3, 3, 1, 1'b0, cyc, sd, dn, er);
      rd_row(1, v); chk(v == '1, "R1", "sequence write to row 1", 64'(v), 64'hffff);

      // R11: host write then read
      wr_row(9, 16'h1234);
      rd_row(9, v); chk(v == 16'h1234, "R11", "host write visible", 64'(v), 64'h1234);

      // R9: running off the end
      run_seq(60, 2, 2, 9, 1'b0, cyc, sd, dn, er);
      chk(er == 1'b1, "R9", "err set", 64'(er), 64'd1);
      chk(!sd, "R9", "no done on run-off", 64'(sd), 64'd0);
      chk(cyc == 5, "R9", "run-off cycle", 64'(cyc), 64'd5);
      rd_row(9, v); chk(v == 16'h1234, "R9", "result row untouched", 64'(v), 64'h1234);
      repeat (3) @(posedge clk);
      #1 chk(err == 1'b1, "R9", "err holds while idle", 64'(err), 64'd1);
      run_seq(12, 2, 3, 6, 1'b0, cyc, sd, dn, er);
      chk(!er && sd, "R9", "err cleared by new start", 64'(er), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule